// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block watches the commands a memory controller sends to a multi-rank DRAM. Every cycle it says whether a proposed command may issue without breaking a device timing rule. The proposed command comes with its rank and bank, and the controller's scheduler presents it on the candidate inputs. The block answers combinationally with a legal flag and with the number of cycles still to wait. When the scheduler raises the issue strobe, the candidate counts as sent. On the next clock edge the checker loads its timers from it.

The block keeps three kinds of state. Each bank has timers for the activate rule, the column rule and the precharge rule. Each rank has timers for read and write spacing, which also cover bus turnaround between ranks. Each rank also keeps a short history of its recent activates to enforce the four-activate window. A timer loads the largest delay that any rule demands. It then counts down by one each cycle and stops at zero. A derived delay of one cycle or less adds no wait.

Top module: `dram_timing_checker`

## Requirements
- R1: After ACTIVATE (code 0) to a bank, READ (code 1) or WRITE (code 2) to that same bank waits 9 cycles (row-to-column delay).
- R2: After ACTIVATE to a bank, another ACTIVATE to that bank waits 33 cycles and PRECHARGE (code 3) to it waits 24 cycles.
- R3: After PRECHARGE to a bank, ACTIVATE to that bank waits 9 cycles.
- R4: READ after READ, or WRITE after WRITE, waits 4 cycles in the same rank and 5 cycles (burst 4 plus rank switch 1) in another rank.
- R5: READ after WRITE waits 16 cycles (write latency 7 + burst 4 + write-to-read 5) in the same rank. In another rank it waits 3 cycles (7 + 4 + 1 - read latency 9).
- R6: WRITE after READ waits 7 cycles (9 + 4 + 1 - 7) in any rank. In another rank the 5-cycle rank switch also applies, and the larger of the two delays wins.
- R7: PRECHARGE after READ to the same bank waits 5 cycles (4 + 5 - 4). PRECHARGE after WRITE to the same bank waits 21 cycles (7 + 4 + 10).
- R8: A rank accepts at most four ACTIVATEs in any 20-cycle window. A fifth ACTIVATE waits until the oldest of the last four is 20 cycles old.
- R9: REFRESH (code 4) to a rank is legal once every bank of that rank could accept an ACTIVATE, with the four-activate window ignored. After REFRESH, ACTIVATE and REFRESH to that rank wait 40 cycles.
- R10: The wait output gives the exact number of cycles until the candidate becomes legal, as the largest wait that any applicable rule demands. The legal flag is high exactly when that wait is zero.
- R11: After reset every command to every rank and bank is legal with zero wait.
- R12: State changes only on the issue strobe. Codes 5 to 7 are no-ops: they are always legal and change no timer when issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| candCmd | input | 3 | Proposed command code (0 ACT, 1 RD, 2 WR, 3 PRE, 4 REF, 5-7 no-op) |
| candRank | input | 1 | Rank of the proposed command |
| candBank | input | 3 | Bank of the proposed command |
| issueValid | input | 1 | The candidate is issued this cycle |
| cmdLegal | output | 1 | Candidate may issue now |
| waitCycles | output | 6 | Cycles until the candidate becomes legal |

## Verification
The case to watch is an issue strobe that loads a timer in the same cycle that timer reaches zero. Another case is a new activate arriving just as an old entry leaves the four-activate window. In both cases the pending countdown and the new delay must merge as a maximum, and the output must still show the state before the issue. The bench provokes these cases by issuing commands on the first cycle they become legal, across several ranks and banks. A behavioural model keeps a list of time-stamped issues and the last four activates of each rank. The design's wait and legal outputs are compared with that model on every cycle.

// File: rtl/dram_chk_pkg.sv
package dram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_WR  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4
  } dramCmd_e;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic rfsh;
  } cmdFlags_t;

  function automatic cmdFlags_t decodeCmd(input logic [2:0] code);
    cmdFlags_t f;
    f = '0;
    case (code)
      CMD_ACT: f.act  = 1'b1;
      CMD_RD:  f.rd   = 1'b1;
      CMD_WR:  f.wr   = 1'b1;
      CMD_PRE: f.pre  = 1'b1;
      CMD_REF: f.rfsh = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_chk_ctrl.sv
module dram_chk_ctrl
  import dram_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] candCmd,
  input  logic       issueValid,
  output cmdFlags_t  candSel,
  output cmdFlags_t  issueStb
);

  always_comb begin
    candSel  = decodeCmd(candCmd);
    issueStb = issueValid ? candSel : '0;
  end

  // R12: at most one update strobe per cycle; no-op codes raise none
  assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueStb));

endmodule

// File: rtl/dram_chk_faw.sv
module dram_chk_faw #(
  parameter int CW     = 6,
  parameter int DEPTH  = 4,
  parameter int WINDOW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          actHit,
  output logic [CW-1:0] oldestWait
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LOADV = (WINDOW > 1) ? CW'(WINDOW - 1) : '0;
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [CW-1:0] slot [DEPTH];
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++)
        slot[k] <= (slot[k] == '0) ? '0 : slot[k] - 1'b1;
      if (actHit) begin
        slot[ptr] <= LOADV;
        ptr       <= (ptr == LASTP) ? '0 : ptr + 1'b1;
      end
    end
  end

  assign oldestWait = slot[ptr];

  // R8: without a new activate the window wait can only shrink
  assert_faw_nogrow_R8: assert property (@(posedge clk) disable iff (!rstN)
    !actHit |=> oldestWait <= $past(oldestWait));

endmodule

// File: rtl/dram_chk_datapath.sv
module dram_chk_datapath
  import dram_chk_pkg::*;
#(
  parameter int NR = 2, parameter int NB = 8,
  parameter int RW = 1, parameter int BW = 3, parameter int CW = 6,
  parameter int T_RCD = 9, parameter int T_RC = 33, parameter int T_RAS = 24,
  parameter int T_RP = 9, parameter int T_CCD = 4, parameter int T_BUS = 4,
  parameter int T_WL = 7, parameter int T_RL = 9, parameter int T_WR = 10,
  parameter int T_RTP = 5, parameter int T_WTR = 5, parameter int T_RTRS = 1,
  parameter int T_FAW = 20, parameter int T_RFC = 40, parameter int FAW_ACTS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  cmdFlags_t     issueStb,
  input  logic [RW-1:0] issueRank,
  input  logic [BW-1:0] issueBank,
  input  cmdFlags_t     candSel,
  input  logic [RW-1:0] candRank,
  input  logic [BW-1:0] candBank,
  output logic [CW-1:0] waitCycles,
  output logic          cmdLegal
);

  function automatic logic [CW-1:0] ldv(input int d);
    return (d > 1) ? CW'(d - 1) : '0;
  endfunction
  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction
  function automatic logic [CW-1:0] dec(input logic [CW-1:0] a);
    return (a == '0) ? '0 : a - 1'b1;
  endfunction

  localparam logic [CW-1:0] L_RCD   = ldv(T_RCD);
  localparam logic [CW-1:0] L_RC    = ldv(T_RC);
  localparam logic [CW-1:0] L_RAS   = ldv(T_RAS);
  localparam logic [CW-1:0] L_RP    = ldv(T_RP);
  localparam logic [CW-1:0] L_CCD   = ldv(T_CCD);
  localparam logic [CW-1:0] L_RFC   = ldv(T_RFC);
  localparam int D_RKRK   = T_BUS + T_RTRS;
  localparam int D_RTOW   = T_RL + T_BUS + T_RTRS - T_WL;
  localparam logic [CW-1:0] L_RKRK  = ldv(D_RKRK);
  localparam logic [CW-1:0] L_RTOW  = ldv(D_RTOW);
  localparam logic [CW-1:0] L_RTOWX = ldv(maxInt(D_RTOW, D_RKRK));
  localparam logic [CW-1:0] L_WTOR  = ldv(T_WL + T_BUS + T_WTR);
  localparam logic [CW-1:0] L_WTORX = ldv(T_WL + T_BUS + T_RTRS - T_RL);
  localparam logic [CW-1:0] L_RTOP  = ldv(T_BUS + T_RTP - T_CCD);
  localparam logic [CW-1:0] L_WTOP  = ldv(T_WL + T_BUS + T_WR);

  logic [CW-1:0] actW [NR][NB];
  logic [CW-1:0] colW [NR][NB];
  logic [CW-1:0] preW [NR][NB];
  logic [CW-1:0] rdW  [NR];
  logic [CW-1:0] wrW  [NR];
  logic [CW-1:0] actN [NR][NB];
  logic [CW-1:0] colN [NR][NB];
  logic [CW-1:0] preN [NR][NB];
  logic [CW-1:0] rdN  [NR];
  logic [CW-1:0] wrN  [NR];
  logic [CW-1:0] fawWait [NR];

  genvar g;
  generate
    for (g = 0; g < NR; g++) begin : gFaw
      dram_chk_faw #(.CW(CW), .DEPTH(FAW_ACTS), .WINDOW(T_FAW)) fawU (
        .clk(clk), .rstN(rstN),
        .actHit(issueStb.act && (issueRank == RW'(g))),
        .oldestWait(fawWait[g])
      );
    end
  endgenerate

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rdN[r] = dec(rdW[r]);
      wrN[r] = dec(wrW[r]);
      if (issueStb.rd) begin
        rdN[r] = mx(rdN[r], (issueRank == RW'(r)) ? L_CCD  : L_RKRK);
        wrN[r] = mx(wrN[r], (issueRank == RW'(r)) ? L_RTOW : L_RTOWX);
      end
      if (issueStb.wr) begin
        wrN[r] = mx(wrN[r], (issueRank == RW'(r)) ? L_CCD  : L_RKRK);
        rdN[r] = mx(rdN[r], (issueRank == RW'(r)) ? L_WTOR : L_WTORX);
      end
      for (int b = 0; b < NB; b++) begin
        actN[r][b] = dec(actW[r][b]);
        colN[r][b] = dec(colW[r][b]);
        preN[r][b] = dec(preW[r][b]);
        if (issueRank == RW'(r)) begin
          if (issueStb.rfsh) actN[r][b] = mx(actN[r][b], L_RFC);
          if (issueBank == BW'(b)) begin
            if (issueStb.act) begin
              actN[r][b] = mx(actN[r][b], L_RC);
              colN[r][b] = mx(colN[r][b], L_RCD);
              preN[r][b] = mx(preN[r][b], L_RAS);
            end
            if (issueStb.pre) actN[r][b] = mx(actN[r][b], L_RP);
            if (issueStb.rd)  preN[r][b] = mx(preN[r][b], L_RTOP);
            if (issueStb.wr)  preN[r][b] = mx(preN[r][b], L_WTOP);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NR; r++) begin
        rdW[r] <= '0;
        wrW[r] <= '0;
        for (int b = 0; b < NB; b++) begin
          actW[r][b] <= '0;
          colW[r][b] <= '0;
          preW[r][b] <= '0;
        end
      end
    end else begin
      for (int r = 0; r < NR; r++) begin
        rdW[r] <= rdN[r];
        wrW[r] <= wrN[r];
        for (int b = 0; b < NB; b++) begin
          actW[r][b] <= actN[r][b];
          colW[r][b] <= colN[r][b];
          preW[r][b] <= preN[r][b];
        end
      end
    end
  end

  always_comb begin
    waitCycles = '0;
    if (candSel.act)
      waitCycles = mx(actW[candRank][candBank], fawWait[candRank]);
    else if (candSel.rd)
      waitCycles = mx(colW[candRank][candBank], rdW[candRank]);
    else if (candSel.wr)
      waitCycles = mx(colW[candRank][candBank], wrW[candRank]);
    else if (candSel.pre)
      waitCycles = preW[candRank][candBank];
    else if (candSel.rfsh)
      for (int b = 0; b < NB; b++) waitCycles = mx(waitCycles, actW[candRank][b]);
  end

  assign cmdLegal = (waitCycles == '0);

  // R1: an activate blocks column access to its bank for the row-to-column delay
  assert_act_col_R1: assert property (@(posedge clk) disable iff (!rstN)
    issueStb.act |=> colW[$past(issueRank)][$past(issueBank)] >= L_RCD);
  // R2: an activate blocks a second activate to its bank for the row cycle
  assert_act_act_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueStb.act |=> actW[$past(issueRank)][$past(issueBank)] >= L_RC);
  // R3: a precharge blocks the next activate to its bank
  assert_pre_act_R3: assert property (@(posedge clk) disable iff (!rstN)
    issueStb.pre |=> actW[$past(issueRank)][$past(issueBank)] >= L_RP);
  // R7: a write blocks precharge of its bank for write recovery
  assert_wr_pre_R7: assert property (@(posedge clk) disable iff (!rstN)
    issueStb.wr |=> preW[$past(issueRank)][$past(issueBank)] >= L_WTOP);

endmodule

// File: rtl/dram_timing_checker.sv
module dram_timing_checker
  import dram_chk_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int T_RCD = 9,  parameter int T_RC = 33, parameter int T_RAS = 24,
  parameter int T_RP = 9,   parameter int T_CCD = 4, parameter int T_BUS = 4,
  parameter int T_WL = 7,   parameter int T_RL = 9,  parameter int T_WR = 10,
  parameter int T_RTP = 5,  parameter int T_WTR = 5, parameter int T_RTRS = 1,
  parameter int T_FAW = 20, parameter int T_RFC = 40, parameter int FAW_ACTS = 4,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int MAX_D  = maxInt(maxInt(maxInt(T_RC, T_RFC), maxInt(T_WL + T_BUS + T_WR, T_FAW)),
                                 maxInt(maxInt(T_RAS, T_WL + T_BUS + T_WTR),
                                        maxInt(T_RL + T_BUS + T_RTRS, T_RCD + T_RP))),
  localparam int CNT_W  = $clog2(MAX_D + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        candCmd,
  input  logic [RANK_W-1:0] candRank,
  input  logic [BANK_W-1:0] candBank,
  input  logic              issueValid,
  output logic              cmdLegal,
  output logic [CNT_W-1:0]  waitCycles
);

  cmdFlags_t candSel;
  cmdFlags_t issueStb;

  dram_chk_ctrl ctrlU (
    .clk(clk), .rstN(rstN), .candCmd(candCmd), .issueValid(issueValid),
    .candSel(candSel), .issueStb(issueStb)
  );

  dram_chk_datapath #(
    .NR(NUM_RANKS), .NB(NUM_BANKS), .RW(RANK_W), .BW(BANK_W), .CW(CNT_W),
    .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CCD(T_CCD),
    .T_BUS(T_BUS), .T_WL(T_WL), .T_RL(T_RL), .T_WR(T_WR), .T_RTP(T_RTP),
    .T_WTR(T_WTR), .T_RTRS(T_RTRS), .T_FAW(T_FAW), .T_RFC(T_RFC), .FAW_ACTS(FAW_ACTS)
  ) dpU (
    .clk(clk), .rstN(rstN),
    .issueStb(issueStb), .issueRank(candRank), .issueBank(candBank),
    .candSel(candSel), .candRank(candRank), .candBank(candBank),
    .waitCycles(waitCycles), .cmdLegal(cmdLegal)
  );

endmodule

// File: tb/dram_timing_checker_tb_top.sv
`timescale 1ns/1ps
module dram_timing_checker_tb_top;

  localparam int tRC = 33, tRCD = 9, tRAS = 24, tRP = 9, tCCD = 4;
  localparam int rkSwitch = 5, rdToWr = 7, wrToRdSame = 16, wrToRdOther = 3;
  localparam int rdToPre = 5, wrToPre = 21, tFAW = 20, tRFC = 40;

  typedef struct { int t; int c; int r; int b; } issue_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] candCmd = '0;
  logic candRank = 1'b0;
  logic [2:0] candBank = '0;
  logic issueValid = 1'b0;
  logic cmdLegal;
  logic [5:0] waitCycles;

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;
  issue_t hist[$];
  int actT[2][$];

  always #2.5 clk = ~clk;

  dram_timing_checker dut_i (
    .clk(clk), .rstN(rstN), .candCmd(candCmd), .candRank(candRank),
    .candBank(candBank), .issueValid(issueValid), .cmdLegal(cmdLegal),
    .waitCycles(waitCycles)
  );

  function automatic int delayOf(issue_t p, int c, int r, int b);
    bit sameR = (p.r == r);
    bit sameB = sameR && (p.b == b);
    case (p.c)
      0: if (sameB) return (c == 0) ? tRC : (c == 1 || c == 2) ? tRCD : (c == 3) ? tRAS : 0;
      1: begin
           if (c == 1) return sameR ? tCCD : rkSwitch;
           if (c == 2) return rdToWr;
           if (c == 3 && sameB) return rdToPre;
         end
      2: begin
           if (c == 2) return sameR ? tCCD : rkSwitch;
           if (c == 1) return sameR ? wrToRdSame : wrToRdOther;
           if (c == 3 && sameB) return wrToPre;
         end
      3: if (sameB && c == 0) return tRP;
      4: if (sameR && c == 0) return tRFC;
      default: return 0;
    endcase
    return 0;
  endfunction

  function automatic int modelWait(int c, int r, int b);
    int e = cyc;
    if (c > 4) return 0;
    if (c == 4) begin
      for (int bb = 0; bb < 8; bb++)
        foreach (hist[i]) if (hist[i].t + delayOf(hist[i], 0, r, bb) > e)
          e = hist[i].t + delayOf(hist[i], 0, r, bb);
    end else begin
      foreach (hist[i]) if (hist[i].t + delayOf(hist[i], c, r, b) > e)
        e = hist[i].t + delayOf(hist[i], c, r, b);
      if (c == 0 && actT[r].size() >= 4 && actT[r][actT[r].size() - 4] + tFAW > e)
        e = actT[r][actT[r].size() - 4] + tFAW;
    end
    return e - cyc;
  endfunction

  function automatic string tagFor(int c);
    case (c)
      0: return "R2 R3 R8 act";
      1: return "R1 R4 R5 rd";
      2: return "R1 R4 R6 wr";
      3: return "R2 R7 pre";
      4: return "R9 ref";
      default: return "R12 noop";
    endcase
  endfunction

  task automatic check(int act, int exp, string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic runCycle(int c, int r, int b, bit want, string tag, output bit issued);
    int expW;
    string t;
    candCmd = 3'(c); candRank = 1'(r); candBank = 3'(b);
    #1;
    expW = modelWait(c, r, b);
    t = (tag != "") ? tag : tagFor(c);
    check(int'(waitCycles), expW, {t, " wait"});
    check(int'(cmdLegal), (expW == 0) ? 1 : 0, {t, " R10 legal"});
    issued = want && (expW == 0);
    issueValid = issued;
    @(posedge clk);
    if (issued && c <= 4) begin
      issue_t e;
      e.t = cyc; e.c = c; e.r = r; e.b = b;
      hist.push_back(e);
      if (c == 0) begin
        actT[r].push_back(cyc);
        if (actT[r].size() > 4) void'(actT[r].pop_front());
      end
    end
    cyc++;
    while (hist.size() > 0 && hist[0].t + 64 < cyc) void'(hist.pop_front());
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic issueWhenLegal(int c, int r, int b, string tag);
    bit iss = 0;
    while (!iss) runCycle(c, r, b, 1'b1, tag, iss);
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    bit iss;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: everything legal straight after reset
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 2; r++)
        for (int b = 0; b < 8; b++) runCycle(c, r, b, 1'b0, "R11 reset", iss);
    // R8: five activates in one rank, the fifth waits on the window
    for (int b = 0; b < 5; b++) issueWhenLegal(0, 0, b, "R8 faw");
    issueWhenLegal(1, 0, 0, "R1 R4 rd after act");
    issueWhenLegal(2, 0, 1, "R6 wr after rd");
    issueWhenLegal(1, 0, 2, "R5 rd after wr same rank");
    issueWhenLegal(2, 1, 2, "R6 wr other rank");
    issueWhenLegal(1, 0, 3, "R5 rd after wr other rank");
    issueWhenLegal(3, 0, 1, "R7 pre after wr");
    issueWhenLegal(3, 0, 3, "R7 pre after rd");
    issueWhenLegal(0, 0, 1, "R3 act after pre");
    issueWhenLegal(0, 0, 0, "R2 act after act");
    issueWhenLegal(4, 1, 0, "R9 ref");
    issueWhenLegal(0, 1, 3, "R9 act after ref");
    issueWhenLegal(7, 1, 3, "R12 noop issued");
    // mixed traffic, issuing as soon as allowed
    for (int n = 0; n < 20000; n++) begin
      int sel = $urandom_range(0, 19);
      int c = (sel < 6) ? 0 : (sel < 10) ? 1 : (sel < 14) ? 2 : (sel < 17) ? 3 :
              (sel == 17) ? 4 : $urandom_range(5, 7);
      runCycle(c, $urandom_range(0, 1), $urandom_range(0, 7),
               $urandom_range(0, 9) < 7, "", iss);
    end
    summary();
  end

endmodule